// File: doc/BRIEF.md
# Scanline Horizontal Slot Sequencer

This block paces a tile-based video processor through each scanline as a series of 8-bit access slots. Each pulse on `slot_en` moves it one slot. The slot numbering is not contiguous. In the wide (40-column) width the count goes from 182 straight to 229. In the narrow (32-column) width it goes from 147 straight to 233. In both widths it wraps through 255 to 0. Every fixed event on the line is decoded from the slot number, and the slot numbers of those events depend on the width. The events are refresh slots, external-access slots, the start of the sprite-table scan, the line-buffer clear and the line advance.

A vertical line counter advances once per line, at the line-advance slot. It runs from 0 up to `TOTAL_LINES-2`, then moves to the all-ones line 0x1FF, which prepares for the active area, and then wraps to 0. The block also reports a display phase and raises a vertical-interrupt strobe. It keeps an interlace field flag that toggles once per frame. The width input is captured only at reset and at each line advance, so a change made in the middle of a line takes effect from the next line.

Top module: `hslot_seq`

## Requirements
- R1: During synchronous reset (`rst_n` low) the block sets the slot to 0, the line to 0, the phase to 0 and the field flag to 0, and it captures `wide_mode` as the width of the first line.
- R2: The slot moves by exactly one step on each clock edge where `slot_en` is high, and it holds its value on every other edge.
- R3: In the wide width the step after slot 182 is 229. In the narrow width the step after slot 147 is 233. Every other step adds one, and 255 wraps to 0.
- R4: `refresh_stb` is high on slots 26, 58, 90 and 122, and also on slot 154 in the wide width. It does this only while the line is below `ACTIVE_LINES`.
- R5: `ext_stb` is high on slots 161 and 162 in the wide width, and on slots 129 and 130 in the narrow width.
- R6: `scan_start_stb` is high on slot 167 (wide) or 135 (narrow). `buf_clr_stb` is high on slot 163 (wide) or 131 (narrow). No two of the refresh, external, scan, clear and advance strobes are high together.
- R7: `line_adv_stb` is high on slot 164 (wide) or 132 (narrow), and the line counter changes only on the edge where it is high.
- R8: The line sequence is 0, 1, …, `TOTAL_LINES-2`, 0x1FF, 0. The phase is 0 (active) for a line below `ACTIVE_LINES`, 2 (preparing) for line 0x1FF, and 1 (inactive) for any other line.
- R9: `vint_stb` is high on slot `VINT_SLOT` of line `ACTIVE_LINES` when `mode5` is 1. When `mode5` is 0 it is high on that slot of line `ACTIVE_LINES+1` instead.
- R10: `field_odd` inverts on the edge where slot 1 of line `ACTIVE_LINES` is taken while `interlace_en` is 1. Otherwise it keeps its value.
- R11: The width is captured only at reset and on the line-advance edge. A change of `wide_mode` in the middle of a line has no effect on the slot sequence or the event positions of that line.
- R12: Every strobe is high only in a cycle where `slot_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | Advance one slot at this edge |
| wide_mode | input | 1 | 1 = 40-column width, 0 = 32-column width |
| mode5 | input | 1 | 1 = native mode, 0 = legacy mode (moves the interrupt one line later) |
| interlace_en | input | 1 | Enable the field toggle |
| slot | output | 8 | Current slot number |
| line | output | LINE_W | Current line number |
| phase | output | 2 | 0 active, 1 inactive, 2 preparing |
| field_odd | output | 1 | Interlace field flag |
| refresh_stb | output | 1 | Refresh slot |
| ext_stb | output | 1 | External-access slot |
| scan_start_stb | output | 1 | Sprite-table scan start |
| buf_clr_stb | output | 1 | Line-buffer clear |
| line_adv_stb | output | 1 | Line advance |
| vint_stb | output | 1 | Vertical interrupt |

## Verification
The hardest case to reach is a width change made in the middle of a line. The current line must finish with its old jump point and old event slots, and the new width must apply from the next advance. The stimulus flips `wide_mode` at slot 100 or slot 60 of a line, then keeps running. The scoreboard must then see, for example, slot 150 still present on a wide line before the narrow numbering starts. Gapped enable patterns and small line counts let several whole frames pass through the 0x1FF wrap, the interrupt line in both modes and the field toggle.

// File: rtl/hslot_pkg.sv
package hslot_pkg;
    localparam int SLOT_W = 8;

    // jump points of the slot counter
    localparam int WIDE_JUMP_FROM   = 182;
    localparam int WIDE_JUMP_TO     = 229;
    localparam int NARROW_JUMP_FROM = 147;
    localparam int NARROW_JUMP_TO   = 233;

    // fixed event slots per width
    localparam int WIDE_EXT_A    = 161;
    localparam int NARROW_EXT_A  = 129;
    localparam int WIDE_CLR      = 163;
    localparam int NARROW_CLR    = 131;
    localparam int WIDE_SCAN     = 167;
    localparam int NARROW_SCAN   = 135;

    // refresh groups: first group base, stride, group counts
    localparam int RFSH_BASE     = 25;
    localparam int RFSH_STRIDE   = 32;
    localparam int RFSH_NARROW_N = 4;
    localparam int RFSH_WIDE_N   = 5;

    typedef enum logic [1:0] {
        PH_ACTIVE   = 2'd0,
        PH_INACTIVE = 2'd1,
        PH_PREP     = 2'd2
    } phase_e;

    typedef struct packed {
        logic refresh;
        logic ext;
        logic scan;
        logic clr;
        logic adv;
        logic vint;
    } evt_t;
endpackage

// File: rtl/hslot_counter.sv
module hslot_counter
    import hslot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wide,
    output logic [SLOT_W-1:0] slot
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) begin
            if (wide && cnt_q.slot == SLOT_W'(WIDE_JUMP_FROM))
                cnt_d.slot = SLOT_W'(WIDE_JUMP_TO);
            else if (!wide && cnt_q.slot == SLOT_W'(NARROW_JUMP_FROM))
                cnt_d.slot = SLOT_W'(NARROW_JUMP_TO);
            else
                cnt_d.slot = cnt_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot = cnt_q.slot;

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(slot));  // R2
    AST_SLOT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !$stable(slot));  // R2
endmodule

// File: rtl/hslot_line_ctrl.sv
module hslot_line_ctrl
    import hslot_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int ACTIVE_LINES = 224,
    parameter int TOTAL_LINES  = 262
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              fld_tgl,
    input  logic              wide_in,
    output logic [LINE_W-1:0] line,
    output phase_e            phase,
    output logic              wide,
    output logic              field
);
    localparam logic [LINE_W-1:0] PREP_LINE = '1;
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 2);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        phase_e            phase;
        logic              wide;
        logic              field;
    } lst_t;

    lst_t lst_d, lst_q;

    always_comb begin
        lst_d = lst_q;
        if (fld_tgl) lst_d.field = !lst_q.field;
        if (adv) begin
            lst_d.wide = wide_in;
            if (lst_q.line == LAST_LINE)      lst_d.line = PREP_LINE;
            else if (lst_q.line == PREP_LINE) lst_d.line = '0;
            else                              lst_d.line = lst_q.line + LINE_W'(1);
            if (lst_d.line == PREP_LINE)                     lst_d.phase = PH_PREP;
            else if (lst_d.line < LINE_W'(ACTIVE_LINES))     lst_d.phase = PH_ACTIVE;
            else                                             lst_d.phase = PH_INACTIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lst_q       <= '0;
            lst_q.phase <= PH_ACTIVE;
            lst_q.wide  <= wide_in;
        end else begin
            lst_q <= lst_d;
        end
    end

    assign line  = lst_q.line;
    assign phase = lst_q.phase;
    assign wide  = lst_q.wide;
    assign field = lst_q.field;

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(line) && $stable(wide));  // R7
    AST_PREP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PREP && adv) |=> (line == '0 && phase == PH_ACTIVE));  // R8
    AST_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fld_tgl |=> $stable(field));  // R10
endmodule

// File: rtl/hslot_event_dec.sv
module hslot_event_dec
    import hslot_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int ACTIVE_LINES = 224,
    parameter int VINT_SLOT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [LINE_W-1:0] line,
    input  logic              wide,
    input  logic              mode5,
    input  logic              interlace_en,
    output evt_t              evt,
    output logic              fld_tgl
);
    logic [RFSH_WIDE_N-1:0] rfsh_hit;
    logic                   on_active;
    logic [LINE_W-1:0]      vint_line;

    for (genvar g = 0; g < RFSH_WIDE_N; g++) begin : g_rfsh
        localparam logic [SLOT_W-1:0] RSLOT = SLOT_W'(RFSH_BASE + g * RFSH_STRIDE + 1);
        if (g < RFSH_NARROW_N) begin : g_both
            assign rfsh_hit[g] = (slot == RSLOT);
        end else begin : g_wide_only
            assign rfsh_hit[g] = (slot == RSLOT) && wide;
        end
    end

    assign on_active = (line < LINE_W'(ACTIVE_LINES));
    assign vint_line = mode5 ? LINE_W'(ACTIVE_LINES) : LINE_W'(ACTIVE_LINES + 1);

    always_comb begin
        evt.refresh = en && on_active && (|rfsh_hit);
        evt.ext     = en && (wide ? (slot == SLOT_W'(WIDE_EXT_A)   || slot == SLOT_W'(WIDE_EXT_A + 1))
                                  : (slot == SLOT_W'(NARROW_EXT_A) || slot == SLOT_W'(NARROW_EXT_A + 1)));
        evt.scan    = en && (slot == (wide ? SLOT_W'(WIDE_SCAN) : SLOT_W'(NARROW_SCAN)));
        evt.clr     = en && (slot == (wide ? SLOT_W'(WIDE_CLR)  : SLOT_W'(NARROW_CLR)));
        evt.adv     = en && (slot == (wide ? SLOT_W'(WIDE_CLR + 1) : SLOT_W'(NARROW_CLR + 1)));
        evt.vint    = en && (slot == SLOT_W'(VINT_SLOT)) && (line == vint_line);
        fld_tgl     = en && interlace_en && (slot == SLOT_W'(1)) && (line == LINE_W'(ACTIVE_LINES));
    end

    AST_STB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |-> en);  // R12
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.refresh, evt.ext, evt.scan, evt.clr, evt.adv}));  // R6
endmodule

// File: rtl/hslot_seq.sv
module hslot_seq
    import hslot_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int ACTIVE_LINES = 224,
    parameter int TOTAL_LINES  = 262,
    parameter int VINT_SLOT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              wide_mode,
    input  logic              mode5,
    input  logic              interlace_en,
    output logic [7:0]        slot,
    output logic [LINE_W-1:0] line,
    output logic [1:0]        phase,
    output logic              field_odd,
    output logic              refresh_stb,
    output logic              ext_stb,
    output logic              scan_start_stb,
    output logic              buf_clr_stb,
    output logic              line_adv_stb,
    output logic              vint_stb
);
    logic              wide_q;
    logic              fld_tgl;
    evt_t              evt;
    phase_e            ph;
    logic [SLOT_W-1:0] slot_w;

    hslot_counter u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (slot_en),
        .wide (wide_q),
        .slot (slot_w)
    );

    hslot_event_dec #(
        .LINE_W      (LINE_W),
        .ACTIVE_LINES(ACTIVE_LINES),
        .VINT_SLOT   (VINT_SLOT)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (slot_en),
        .slot        (slot_w),
        .line        (line),
        .wide        (wide_q),
        .mode5       (mode5),
        .interlace_en(interlace_en),
        .evt         (evt),
        .fld_tgl     (fld_tgl)
    );

    hslot_line_ctrl #(
        .LINE_W      (LINE_W),
        .ACTIVE_LINES(ACTIVE_LINES),
        .TOTAL_LINES (TOTAL_LINES)
    ) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (evt.adv),
        .fld_tgl(fld_tgl),
        .wide_in(wide_mode),
        .line   (line),
        .phase  (ph),
        .wide   (wide_q),
        .field  (field_odd)
    );

    assign slot           = slot_w;
    assign phase          = ph;
    assign refresh_stb    = evt.refresh;
    assign ext_stb        = evt.ext;
    assign scan_start_stb = evt.scan;
    assign buf_clr_stb    = evt.clr;
    assign line_adv_stb   = evt.adv;
    assign vint_stb       = evt.vint;

    AST_ADV_MOVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv_stb |=> !$stable(line));  // R7
endmodule

// File: tb/hslot_seq_tb.sv
module hslot_seq_tb;
    localparam int AL = 3;
    localparam int TL = 7;
    localparam int VS = 0;

    logic       clk = 1'b0;
    logic       rst_n, slot_en, wide_mode, mode5, interlace_en;
    logic [7:0] slot;
    logic [8:0] line;
    logic [1:0] phase;
    logic       field_odd, refresh_stb, ext_stb, scan_start_stb, buf_clr_stb, line_adv_stb, vint_stb;

    always #5 clk = ~clk;

    hslot_seq #(.LINE_W(9), .ACTIVE_LINES(AL), .TOTAL_LINES(TL), .VINT_SLOT(VS)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .wide_mode(wide_mode), .mode5(mode5),
        .interlace_en(interlace_en), .slot(slot), .line(line), .phase(phase), .field_odd(field_odd),
        .refresh_stb(refresh_stb), .ext_stb(ext_stb), .scan_start_stb(scan_start_stb),
        .buf_clr_stb(buf_clr_stb), .line_adv_stb(line_adv_stb), .vint_stb(vint_stb)
    );

    typedef struct {
        int    slot, line, ph, fld;
        bit    en;
        bit    s_rf, s_ex, s_sc, s_cl, s_ad, s_vi;
        string srq;
    } item_t;

    item_t q[$];
    int    vectors = 0, errs = 0;
    int    m_slot, m_line, m_ph, m_fld, m_wide;
    string slot_req = "R2/R3";
    bit    done = 0;

    task automatic check(string rq, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", rq, what, act, exp, $time);
        end
    endtask

    task automatic cmp(string rq, string what, int act, int exp);
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", rq, what, act, exp, $time);
        end
    endtask

    // driver: applies one cycle and pushes its expected outputs
    task automatic cyc(bit e);
        item_t it;
        int    s;
        bit    w, adv_now;
        @(negedge clk);
        slot_en = e;
        s = m_slot; w = m_wide[0];
        it.slot = m_slot; it.line = m_line; it.ph = m_ph; it.fld = m_fld; it.en = e; it.srq = slot_req;
        it.s_rf = e && (m_line < AL) && (s == 26 || s == 58 || s == 90 || s == 122 || (w && s == 154));
        it.s_ex = e && (w ? (s == 161 || s == 162) : (s == 129 || s == 130));
        it.s_sc = e && (s == (w ? 167 : 135));
        it.s_cl = e && (s == (w ? 163 : 131));
        adv_now = e && (s == (w ? 164 : 132));
        it.s_ad = adv_now;
        it.s_vi = e && (s == VS) && (m_line == (mode5 ? AL : AL + 1));
        q.push_back(it);
        if (e) begin
            if (interlace_en && m_line == AL && s == 1) m_fld ^= 1;
            if (w && s == 182)       m_slot = 229;
            else if (!w && s == 147) m_slot = 233;
            else                     m_slot = (s + 1) % 256;
            if (adv_now) begin
                if (m_line == TL - 2)   m_line = 511;
                else if (m_line == 511) m_line = 0;
                else                    m_line = m_line + 1;
                m_ph   = (m_line == 511) ? 2 : (m_line < AL ? 0 : 1);
                m_wide = wide_mode;
                slot_req = "R2/R3";
            end
        end
    endtask

    task automatic run_to_slot(int s);
        for (int k = 0; k < 400 && m_slot != s; k++) cyc(1'b1);
    endtask

    // monitor: pops expected items and compares
    initial begin
        item_t it;
        string srq;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                vectors++;
                srq = it.en ? "" : "R12";
                cmp(it.srq, "slot", slot, it.slot);
                cmp("R8", "line", line, it.line);
                cmp("R8", "phase", phase, it.ph);
                cmp("R10", "field_odd", field_odd, it.fld);
                cmp(it.en ? "R4" : srq, "refresh_stb", refresh_stb, it.s_rf);
                cmp(it.en ? "R5" : srq, "ext_stb", ext_stb, it.s_ex);
                cmp(it.en ? "R6" : srq, "scan_start_stb", scan_start_stb, it.s_sc);
                cmp(it.en ? "R6" : srq, "buf_clr_stb", buf_clr_stb, it.s_cl);
                cmp(it.en ? "R7" : srq, "line_adv_stb", line_adv_stb, it.s_ad);
                cmp(it.en ? "R9" : srq, "vint_stb", vint_stb, it.s_vi);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; slot_en = 1'b0; wide_mode = 1'b1; mode5 = 1'b1; interlace_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R1", "reset slot", slot, 0);
        check("R1", "reset line", line, 0);
        check("R1", "reset phase", phase, 0);
        check("R1", "reset field", field_odd, 0);
        m_slot = 0; m_line = 0; m_ph = 0; m_fld = 0; m_wide = 1;

        // wide width, native mode, interlace: two full frames
        for (int i = 0; i < 2 * TL * 210 + 50; i++) cyc(1'b1);
        // gapped enable pattern
        for (int i = 0; i < 3000; i++) cyc((i % 3) != 0 && (i % 7) != 5);

        // R11: narrow requested mid wide line; this line keeps its wide numbering
        run_to_slot(100);
        wide_mode = 1'b0; mode5 = 1'b0; interlace_en = 1'b0;
        slot_req = "R11";
        for (int i = 0; i < 2 * TL * 171 + 300; i++) cyc(1'b1);

        // R11: wide requested mid narrow line
        run_to_slot(60);
        wide_mode = 1'b1; interlace_en = 1'b1;
        slot_req = "R11";
        for (int i = 0; i < 2 * TL * 210 + 50; i++) cyc((i % 5) != 2);

        // back to native mode, idle stretch then run
        mode5 = 1'b1;
        for (int i = 0; i < 20; i++) cyc(1'b0);
        for (int i = 0; i < TL * 210 + 20; i++) cyc(1'b1);

        @(negedge clk);
        slot_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule